// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block supervises software timing and control flow. Once enabled, a counter advances on every cycle of the oscillator clock the block is placed on. Software must service the watchdog before the counter reaches a programmed 32-bit limit. An optional lower bound, the window start, makes a service that arrives too early a fault. An optional keyed mode replaces the plain service write with a two-write handshake. The two values software must write come from a 16-bit linear feedback shift register in the block. Software can read both values.

A late service, an early service, a wrong key, or a key written in the wrong order raises a fault event. Every fault event starts a reset request pulse of fixed length. A lock bit freezes all configuration until the next reset, so a runaway program cannot disable its own supervisor. The register interface is a plain single-cycle write strobe plus a read strobe with a registered read port, all in the same clock domain as the counter.

Register offsets (`addr`): 0 control, 1 timeout limit, 2 window start, 3 service, 4 keys (read only), 5 live count (read only).

Top module: `wdg_keyed_window`

## Requirements
- R1: Control bit 0 enables the counter and reads back as written. While it is clear, the count stays 0, and service writes raise no event and do not advance the keys.
- R2: Writing control bit 1 as 1 locks the block. After that, writes to control (offset 0), timeout (offset 1) and window (offset 2) have no effect until reset. Service writes are still accepted.
- R3: Take the edge that writes enable as edge 0. The count is 0 up to edge 1 and then rises by one per cycle. When the count is at or above the timeout limit, `expire_evt` is high for one cycle after the next edge, and the count restarts from 0. With a limit of 20, the event appears 21 cycles after the enabling write.
- R4: In plain mode (control bit 3 clear), any write to offset 3 while enabled is an accepted service when outside any active window. An accepted service clears the count.
- R5: With control bit 2 set, a service while the count is below the window start is rejected. It raises `bad_service_evt` one cycle later and clears the count. A service at or after the window start is accepted.
- R6: If the window start is greater than the timeout limit, the window check is off even when control bit 2 is set.
- R7: In keyed mode (control bit 3 set), a service needs two writes to offset 3. The first carries key A in bits 15:0 and the second carries key B. Offset 4 reads {key B, key A}. Key B is the LFSR successor of key A.
- R8: In keyed mode, a first write that is not key A raises `bad_service_evt`, and so does a second write that is not key B. Writing key B first is one such case. The handshake then restarts from key A.
- R9: The key register resets to 0xACE1 and steps as a right-shifting Galois LFSR with mask 0xB400. After each accepted service it advances by two steps, so the next key A is the old key B's successor.
- R10: Each fault event drives `reset_req` high for 16 consecutive cycles, starting on the same edge as the event. A new fault during the pulse restarts the 16-cycle count.
- R11: Expiry has priority. A service write in the cycle where the count reaches the limit is ignored, and only `expire_evt` is raised. The two event outputs are never high together.
- R12: A read strobe loads `rdata` at the next edge with the register selected by `addr`. Timeout resets to 1000, window start to 0, and control to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock for counter and registers |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, loads rdata at the next edge |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| expire_evt | output | 1 | One-cycle pulse on counter expiry |
| bad_service_evt | output | 1 | One-cycle pulse on an early or wrong service |
| reset_req | output | 1 | Reset request pulse, 16 cycles, retriggerable |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 16-bit key generator seeded 0xACE1, a 16-cycle request pulse and a reset limit of 1000. It programs limits of 20, 30 and 200 cycles, which brings expiry, window rejection, and the exact expiry-versus-service collision cycle within a few dozen clocks. The 16-cycle pulse is shorter than the 20-cycle limit, so a retriggered pulse can be told apart from two separate ones. The keyed sequence is driven from values read back at offset 4. This checks both the key relation and the double-step advance without any access to internal state.

// File: rtl/wdg_pkg.sv
// Package: shared register offsets, control layout and the key step function.
// Assumes a single clock domain for register access and counting.
package wdg_pkg;

    localparam int ADDR_W = 3;
    localparam int KEY_W  = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_TMO  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_WIN  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_SVC  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_KEYS = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd5;

    // Control register, bit 0 at the bottom.
    typedef struct packed {
        logic keyed;   // bit 3
        logic win_en;  // bit 2
        logic lock;    // bit 1
        logic en;      // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // One step of a right-shifting Galois LFSR.
    function automatic logic [KEY_W-1:0] key_step(input logic [KEY_W-1:0] s,
                                                  input logic [KEY_W-1:0] mask);
        return s[0] ? ((s >> 1) ^ mask) : (s >> 1);
    endfunction

endpackage

// File: rtl/wdg_keygen.sv
// Key generator: holds the current key A and offers key B, its LFSR successor.
// On advance the state moves two steps, so new key A follows old key B.
// Assumes a non-zero seed; the all-zero state is never reached from one.
module wdg_keygen
    import wdg_pkg::*;
#(
    parameter logic [KEY_W-1:0] SEED = 16'hACE1,
    parameter logic [KEY_W-1:0] MASK = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [KEY_W-1:0] key_a,
    output logic [KEY_W-1:0] key_b
);

    logic [KEY_W-1:0] state_q;

    // Key state: load seed on reset, double step on each accepted service.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= SEED;
        else if (advance) state_q <= key_step(key_step(state_q, MASK), MASK);
    end

    assign key_a = state_q;
    assign key_b = key_step(state_q, MASK);

    a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state_q));

endmodule

// File: rtl/wdg_counter.sv
// Supervision counter: counts while running, flags expiry at or above the
// limit, and flags a service window violation when the window is valid.
// Assumes clear and expiry both restart from zero on the next edge.
module wdg_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] win_start,
    input  logic             win_en,
    output logic [CNT_W-1:0] count,
    output logic             expired,
    output logic             early
);

    logic [CNT_W-1:0] cnt_q;
    logic             win_valid;

    // Expiry and window decode from the current count.
    always_comb begin
        expired   = run && (cnt_q >= limit);
        win_valid = win_en && (win_start <= limit);
        early     = win_valid && (cnt_q < win_start);
    end

    // Count register: hold zero when idle, restart on service or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (!run || clear || expired) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> cnt_q == '0);
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !expired) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/wdg_pulse.sv
// Reset request stretcher: a trigger produces a registered high level for
// LEN cycles; a trigger during the pulse restarts the length.
// Assumes LEN is at least 1.
module wdg_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic req
);

    localparam int LW = $clog2(LEN + 1);

    logic [LW-1:0] left_q;
    logic          req_q;

    // Remaining-cycle counter and registered request level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q <= trigger || (left_q > LW'(1));
            if (trigger)              left_q <= LW'(LEN);
            else if (left_q != '0)    left_q <= left_q - 1'b1;
        end
    end

    assign req = req_q;

    a_r10_follows: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> req_q);
    a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LW'(LEN));

endmodule

// File: rtl/wdg_keyed_window.sv
// Keyed windowed watchdog top: configuration registers with lock, service
// decode (plain or two-key), event generation and the read port.
// Assumes bus access and counting share the oscillator clock domain.
module wdg_keyed_window
    import wdg_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter logic [31:0]      TMO_RESET = 32'd1000,
    parameter int               PULSE_LEN = 16,
    parameter logic [KEY_W-1:0] KEY_SEED  = 16'hACE1,
    parameter logic [KEY_W-1:0] KEY_MASK  = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              expire_evt,
    output logic              bad_service_evt,
    output logic              reset_req
);

    localparam int CNT_W = DATA_W;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] tmo_q;
    logic [CNT_W-1:0] win_q;
    logic             stage_q;
    logic             exp_q;
    logic             bad_q;
    logic [DATA_W-1:0] rdata_q;

    logic [CNT_W-1:0] count;
    logic             expired;
    logic             early;
    logic [KEY_W-1:0] key_a;
    logic [KEY_W-1:0] key_b;

    logic cfg_wr;
    logic svc_hit;
    logic svc_good;
    logic svc_bad;
    logic svc_half;

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_q.en),
        .clear     (svc_good || svc_bad),
        .limit     (tmo_q),
        .win_start (win_q),
        .win_en    (ctrl_q.win_en),
        .count     (count),
        .expired   (expired),
        .early     (early)
    );

    wdg_keygen #(.SEED(KEY_SEED), .MASK(KEY_MASK)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (svc_good),
        .key_a   (key_a),
        .key_b   (key_b)
    );

    wdg_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (expired || svc_bad),
        .req     (reset_req)
    );

    // Service decode: expiry wins, then window, then plain or keyed check.
    always_comb begin
        cfg_wr   = wr_en && !ctrl_q.lock;
        svc_hit  = wr_en && (addr == OFS_SVC) && ctrl_q.en;
        svc_good = 1'b0;
        svc_bad  = 1'b0;
        svc_half = 1'b0;
        if (svc_hit && !expired) begin
            if (early)             svc_bad = 1'b1;
            else if (!ctrl_q.keyed) svc_good = 1'b1;
            else if (!stage_q) begin
                if (wdata[KEY_W-1:0] == key_a) svc_half = 1'b1;
                else                           svc_bad  = 1'b1;
            end else begin
                if (wdata[KEY_W-1:0] == key_b) svc_good = 1'b1;
                else                           svc_bad  = 1'b1;
            end
        end
    end

    // Configuration registers: writable until the lock bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tmo_q  <= CNT_W'(TMO_RESET);
            win_q  <= '0;
        end else if (cfg_wr) begin
            case (addr)
                OFS_CTRL: ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
                OFS_TMO:  tmo_q  <= wdata;
                OFS_WIN:  win_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Key handshake stage: set after a correct key A, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          stage_q <= 1'b0;
        else if (!ctrl_q.en || expired || svc_bad || svc_good) stage_q <= 1'b0;
        else if (svc_half)                                   stage_q <= 1'b1;
    end

    // Registered one-cycle event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= 1'b0;
            bad_q <= 1'b0;
        end else begin
            exp_q <= expired;
            bad_q <= svc_bad;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_en) begin
            case (addr)
                OFS_CTRL: rdata_q <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
                OFS_TMO:  rdata_q <= tmo_q;
                OFS_WIN:  rdata_q <= win_q;
                OFS_KEYS: rdata_q <= {{(DATA_W-2*KEY_W){1'b0}}, key_b, key_a};
                OFS_CNT:  rdata_q <= count;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign rdata           = rdata_q;
    assign expire_evt      = exp_q;
    assign bad_service_evt = bad_q;

    a_r2_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> $stable(ctrl_q) && $stable(tmo_q) && $stable(win_q));
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exp_q && bad_q));
    a_r10_event_request: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q || bad_q) |-> reset_req);
    a_r5_early_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_hit && early && !expired) |=> bad_q);
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !$past(ctrl_q.en)) |-> !exp_q && !bad_q);

endmodule

// File: tb/sim_wdg_keyed_window.sv
module sim_wdg_keyed_window;

    localparam logic [15:0] SEED = 16'hACE1;
    localparam logic [15:0] MASK = 16'hB400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        expire_evt, bad_service_evt, reset_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wdg_keyed_window u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .expire_evt(expire_evt),
        .bad_service_evt(bad_service_evt), .reset_req(reset_req)
    );

    function automatic logic [15:0] nx(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ MASK) : (s >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every edge.
    bit          m_en, m_lock, m_wen, m_keyed, m_stage, m_req, m_tev, m_bev;
    logic [31:0] m_tmo, m_win, m_cnt, m_rdata;
    logic [15:0] m_key;
    int          m_left;

    always @(posedge clk) begin : model
        bit expire, svc, bad, good, half, winact;
        if (!rst_n) begin
            m_en = 0; m_lock = 0; m_wen = 0; m_keyed = 0; m_stage = 0;
            m_req = 0; m_tev = 0; m_bev = 0; m_tmo = 1000; m_win = 0;
            m_cnt = 0; m_rdata = 0; m_key = SEED; m_left = 0;
        end else begin
            expire = m_en && (m_cnt >= m_tmo);
            svc    = wr_en && addr == 3'd3 && m_en;
            winact = m_wen && (m_win <= m_tmo);
            bad = 0; good = 0; half = 0;
            if (svc && !expire) begin
                if (winact && m_cnt < m_win) bad = 1;
                else if (!m_keyed) good = 1;
                else if (!m_stage) begin
                    if (wdata[15:0] == m_key) half = 1; else bad = 1;
                end else begin
                    if (wdata[15:0] == nx(m_key)) good = 1; else bad = 1;
                end
            end
            if (rd_en) begin
                case (addr)
                    3'd0: m_rdata = {28'd0, m_keyed, m_wen, m_lock, m_en};
                    3'd1: m_rdata = m_tmo;
                    3'd2: m_rdata = m_win;
                    3'd4: m_rdata = {nx(m_key), m_key};
                    3'd5: m_rdata = m_cnt;
                    default: m_rdata = 0;
                endcase
            end
            m_req = expire || bad || (m_left > 1);
            if (expire || bad) m_left = 16; else if (m_left > 0) m_left--;
            m_tev = expire; m_bev = bad;
            if (!m_en || expire || bad || good) m_stage = 0; else if (half) m_stage = 1;
            if (!m_en || expire || bad || good) m_cnt = 0; else m_cnt = m_cnt + 1;
            if (good) m_key = nx(nx(m_key));
            if (wr_en && !m_lock) begin
                case (addr)
                    3'd0: begin m_en = wdata[0]; m_lock = wdata[1];
                                m_wen = wdata[2]; m_keyed = wdata[3]; end
                    3'd1: m_tmo = wdata;
                    3'd2: m_win = wdata;
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(reset_req == m_req, "R10", "model reset_req", reset_req, m_req);
            chk(expire_evt == m_tev, "R3", "model expire_evt", expire_evt, m_tev);
            chk(bad_service_evt == m_bev, "R8", "model bad_service_evt", bad_service_evt, m_bev);
            chk(rdata == m_rdata, "R12", "model rdata", rdata, m_rdata);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            chk(0, "WDOG", "run did not finish", cyc, 100000);
            finish_run();
        end
    end

    // Bus tasks, called at a falling edge, return at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0;
        v = rdata;
    endtask

    initial begin
        logic [31:0] v, k;
        int n;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // Reset state
        rd(3'd0, v); chk(v == 0, "R1", "control after reset", v, 0);
        rd(3'd1, v); chk(v == 1000, "R12", "timeout after reset", v, 1000);
        rd(3'd5, v); chk(v == 0, "R1", "count after reset", v, 0);
        rd(3'd4, v); chk(v == {nx(SEED), SEED}, "R9", "keys after reset", v, {nx(SEED), SEED});

        // Service while disabled is ignored
        wr(3'd3, 32'h1234);
        chk(bad_service_evt == 0, "R1", "service while off raised event", bad_service_evt, 0);
        rd(3'd5, v); chk(v == 0, "R1", "count while off", v, 0);
        rd(3'd4, v); chk(v == {nx(SEED), SEED}, "R1", "keys moved while off", v, {nx(SEED), SEED});

        // Expiry timing and pulse length
        wr(3'd1, 20);
        wr(3'd0, 1);
        n = 0;
        do begin @(negedge clk); n++; end while (!expire_evt && n < 100);
        chk(n == 21, "R3", "cycles from enable to expiry", n, 21);
        n = 0;
        while (reset_req && n < 100) begin n++; @(negedge clk); end
        chk(n == 16, "R10", "reset_req length", n, 16);
        rd(3'd0, v); chk(v[0] == 1, "R1", "enable readback", v[0], 1);

        // Regular plain service keeps it alive
        wr(3'd0, 0); wr(3'd0, 1);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 8; j++) begin @(negedge clk); if (expire_evt) seen = 1; end
            wr(3'd3, 32'hDEAD0000 + i);
            if (expire_evt || bad_service_evt) seen = 1;
        end
        chk(seen == 0, "R4", "event during regular service", seen, 0);

        // Window: early rejected, late accepted
        wr(3'd0, 0); wr(3'd2, 8); wr(3'd0, 5);
        wr(3'd3, 0);
        chk(bad_service_evt == 1, "R5", "early service not rejected", bad_service_evt, 1);
        repeat (10) @(negedge clk);
        wr(3'd3, 0);
        chk(bad_service_evt == 0, "R5", "in-window service rejected", bad_service_evt, 0);

        // Window start above limit disables the window
        wr(3'd0, 0); wr(3'd2, 50); wr(3'd0, 5);
        wr(3'd3, 0);
        chk(bad_service_evt == 0, "R6", "invalid window still enforced", bad_service_evt, 0);

        // Expiry beats a same-cycle service
        wr(3'd0, 0); wr(3'd2, 0); wr(3'd1, 30); wr(3'd0, 1);
        repeat (30) @(negedge clk);
        wr(3'd3, 0);
        chk(expire_evt == 1, "R11", "expiry lost to service", expire_evt, 1);
        chk(bad_service_evt == 0, "R11", "service event at expiry", bad_service_evt, 0);

        // Keyed sequence
        wr(3'd0, 0); wr(3'd1, 200); wr(3'd0, 9);
        rd(3'd4, k);
        chk(k[31:16] == nx(k[15:0]), "R7", "key B successor of key A", k[31:16], nx(k[15:0]));
        wr(3'd3, {16'd0, k[15:0]});
        chk(bad_service_evt == 0, "R7", "key A rejected", bad_service_evt, 0);
        wr(3'd3, {16'd0, k[31:16]});
        chk(bad_service_evt == 0, "R7", "key B rejected", bad_service_evt, 0);
        rd(3'd5, v); chk(v < 4, "R4", "count not cleared by keyed service", v, 3);
        rd(3'd4, v);
        chk(v[15:0] == nx(k[31:16]), "R9", "key advance", v[15:0], nx(k[31:16]));

        // Wrong and out-of-order keys
        k = v;
        wr(3'd3, {16'd0, k[31:16]});
        chk(bad_service_evt == 1, "R8", "key B first accepted", bad_service_evt, 1);
        wr(3'd3, {16'd0, k[15:0]});
        wr(3'd3, {16'd0, ~k[31:16]});
        chk(bad_service_evt == 1, "R8", "wrong key B accepted", bad_service_evt, 1);
        repeat (20) @(negedge clk);
        wr(3'd3, {16'd0, ~k[15:0]});
        chk(bad_service_evt == 1, "R8", "wrong key A accepted", bad_service_evt, 1);
        repeat (4) @(negedge clk);
        wr(3'd3, {16'd0, ~k[15:0]});
        n = 0;
        while (reset_req && n < 100) begin n++; @(negedge clk); end
        chk(n == 16, "R10", "retriggered pulse length", n, 16);

        // Lock freezes configuration
        wr(3'd0, 3);
        wr(3'd1, 5);
        rd(3'd1, v); chk(v == 200, "R2", "timeout changed after lock", v, 200);
        wr(3'd0, 0);
        rd(3'd0, v); chk(v == 3, "R2", "control changed after lock", v, 3);
        wr(3'd3, 0);
        chk(bad_service_evt == 0, "R2", "service refused after lock", bad_service_evt, 0);
        rd(3'd5, v); chk(v < 4, "R2", "locked service did not clear count", v, 3);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule